// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the write engine behind a flash command interface. When the command decoder has accepted a complete program or erase request, it pulses `start`. It also gives the operation type, the target address and the data word. The sequencer then drives an abstract array port through timed steps. Each step runs for a parameterized number of clock cycles, which stands in for real cell timing. Each timed step is followed by a one-cycle verify, where the array reports pass or fail.

A word program is one program step and then a verify. A block erase is longer. It first drives the whole block to zero and verifies that. It then erases the block and verifies that every bit reads one. Any address inside a block selects that block.

The command interface can suspend either operation and later resume it. The ready flag goes high while an operation is suspended, and a separate flag shows whether a program or an erase is parked. Resume continues from the cycles that were left, not from the start of the step. While an erase is suspended, a word program may be run, after which the erase stays suspended until it is resumed. Error flags for supply, lock, program verify and erase verify feed the status register. These flags stay set until they are cleared.

Top module: `flash_seq`

## Requirements
- R1: After reset, `ready`=1, `arr_op`=0, and all of `prog_susp`, `erase_susp`, `vpp_err`, `lock_fail`, `prog_fail` and `erase_fail` are 0.
- R2: A program start (`op_erase`=0) drives `arr_op`=1 for PGM_CYC cycles with `arr_addr`=`addr` and `arr_data`=`wdata`, then `arr_op`=2 for one verify cycle. `ready` is 0 from the cycle after the start until the cycle after the verify.
- R3: An erase start (`op_erase`=1) drives `arr_op`=3 (block to zero) for ZERO_CYC cycles, then 4 (zero verify), then 5 (block erase) for ERS_CYC cycles, then 6 (ones verify). Each of these cycles lasts one clock. `arr_addr` is `addr` with its low BLK_W bits cleared.
- R4: `verify_ok`=0 in a verify cycle sets `prog_fail` for 2, and `erase_fail` for 4 or 6. A failed zero verify ends the erase without any `arr_op`=5 cycle.
- R5: `vpp_err`, `lock_fail`, `prog_fail` and `erase_fail` stay set until a `clr_err` pulse clears them in the next cycle.
- R6: A start with `vpp_ok`=0 sets `vpp_err` and starts nothing: `ready` stays 1 and `arr_op` stays 0.
- R7: A start with `lock_err`=1 sets `lock_fail` and starts nothing.
- R8: `suspend_req` during a program step sets `prog_susp`. During an erase step it sets `erase_susp`. In both cases `ready` goes to 1 and `arr_op` goes to 0 in the next cycle.
- R9: While suspended, `arr_op` stays 0 and a further `suspend_req` has no effect. While a program is suspended, `start` has no effect.
- R10: Resume continues the interrupted step from the count left at suspension. The cycle in which the suspend was taken does not count, so a step suspended once shows its code for its length plus one cycle in total.
- R11: While an erase is suspended, a program start runs a full word program with `erase_susp` held at 1. `suspend_req` is ignored during that program. Afterwards the block returns to erase-suspended with `ready`=1, and `resume_req` completes the erase.
- R12: `start` while an operation is running, and `resume_req` while idle, have no effect.
- R13: Asserting `rst_n` low during an operation aborts it at once: `arr_op` is 0 and `ready` is 1 without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse from the command decoder |
| op_erase | input | 1 | 1 = block erase, 0 = word program |
| addr | input | AW | Target word address |
| wdata | input | DW | Word to program |
| suspend_req | input | 1 | Suspend the running operation |
| resume_req | input | 1 | Resume a suspended operation |
| vpp_ok | input | 1 | Program supply within range |
| lock_err | input | 1 | Target block is locked |
| clr_err | input | 1 | Clear the sticky error flags |
| verify_ok | input | 1 | Array verify result, sampled in verify cycles |
| arr_op | output | 3 | Array step code (0 idle, 1..6 as in R2/R3) |
| arr_addr | output | AW | Word address or block base for the array |
| arr_data | output | DW | Word data during a program step |
| ready | output | 1 | No operation running |
| prog_susp | output | 1 | Program suspended |
| erase_susp | output | 1 | Erase suspended |
| vpp_err | output | 1 | Supply error flag |
| lock_fail | output | 1 | Lock error flag |
| prog_fail | output | 1 | Program verify failure flag |
| erase_fail | output | 1 | Erase verify failure flag |

## Verification
A wrong phase register shows on `arr_op` in the very next cycle, as a skipped, repeated or out-of-order step code. A miscounted step shows one cycle late or early at the transition into its verify code. A lost or mis-restored saved count after resume appears only at the end of the resumed step, as a total step length other than length plus one. Mixing up the saved phase during a nested program appears when that program ends, as the wrong suspend flag or an `arr_op` that is not idle.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW       = 21,
  parameter int DW       = 16,
  parameter int BLK_W    = 15,
  parameter int PGM_CYC  = 8,
  parameter int ZERO_CYC = 12,
  parameter int ERS_CYC  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          suspend_req,
  input  logic          resume_req,
  input  logic          vpp_ok,
  input  logic          lock_err,
  input  logic          clr_err,
  input  logic          verify_ok,
  output logic [2:0]    arr_op,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data,
  output logic          ready,
  output logic          prog_susp,
  output logic          erase_susp,
  output logic          vpp_err,
  output logic          lock_fail,
  output logic          prog_fail,
  output logic          erase_fail
);
  localparam int MAXC = (PGM_CYC > ZERO_CYC) ? ((PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC)
                                             : ((ZERO_CYC > ERS_CYC) ? ZERO_CYC : ERS_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_PGM = 3'd1, S_PVF = 3'd2, S_ZER = 3'd3,
    S_ZVF  = 3'd4, S_ERS = 3'd5, S_EVF = 3'd6, S_SUSP = 3'd7
  } st_t;

  st_t           st, sv_st;
  logic [CW-1:0] cnt, sv_cnt;
  logic          nest;
  logic [AW-1:0] w_addr, b_addr;
  logic [DW-1:0] w_data;

  assign ready      = (st == S_IDLE) || (st == S_SUSP);
  assign prog_susp  = (st == S_SUSP) && (sv_st == S_PGM);
  assign erase_susp = ((st == S_SUSP) && (sv_st != S_PGM)) || nest;
  assign arr_op     = (st == S_SUSP) ? 3'd0 : st;
  assign arr_addr   = (st == S_PGM || st == S_PVF) ? w_addr : b_addr;
  assign arr_data   = (st == S_PGM) ? w_data : '0;

  wire can_start = start && ((st == S_IDLE) || (st == S_SUSP && sv_st != S_PGM && !op_erase));
  wire go        = can_start && vpp_ok && !lock_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sv_st <= S_IDLE; cnt <= '0; sv_cnt <= '0; nest <= 1'b0;
      w_addr <= '0; b_addr <= '0; w_data <= '0;
      vpp_err <= 1'b0; lock_fail <= 1'b0; prog_fail <= 1'b0; erase_fail <= 1'b0;
    end else begin
      if (clr_err) begin
        vpp_err <= 1'b0; lock_fail <= 1'b0; prog_fail <= 1'b0; erase_fail <= 1'b0;
      end
      if (can_start && !vpp_ok) vpp_err <= 1'b1;
      if (can_start && lock_err) lock_fail <= 1'b1;
      case (st)
        S_IDLE, S_SUSP: begin
          if (go && op_erase) begin
            st     <= S_ZER;
            cnt    <= CW'(ZERO_CYC - 1);
            b_addr <= {addr[AW-1:BLK_W], {BLK_W{1'b0}}};
          end else if (go) begin
            st     <= S_PGM;
            cnt    <= CW'(PGM_CYC - 1);
            w_addr <= addr;
            w_data <= wdata;
            nest   <= (st == S_SUSP);
          end else if (st == S_SUSP && resume_req) begin
            st  <= sv_st;
            cnt <= sv_cnt;
          end
        end
        S_PGM, S_ZER, S_ERS: begin
          if (suspend_req && !nest) begin
            sv_st  <= st;
            sv_cnt <= cnt;
            st     <= S_SUSP;
          end else if (cnt == '0) begin
            st <= st_t'(st + 3'd1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PVF: begin
          if (!verify_ok) prog_fail <= 1'b1;
          st   <= nest ? S_SUSP : S_IDLE;
          nest <= 1'b0;
        end
        S_ZVF: begin
          if (!verify_ok) begin
            erase_fail <= 1'b1;
            st         <= S_IDLE;
          end else begin
            st  <= S_ERS;
            cnt <= CW'(ERS_CYC - 1);
          end
        end
        S_EVF: begin
          if (!verify_ok) erase_fail <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       op_erase,
  input logic       vpp_ok,
  input logic       clr_err,
  input logic       resume_req,
  input logic [2:0] arr_op,
  input logic       ready,
  input logic       prog_susp,
  input logic       erase_susp,
  input logic       vpp_err,
  input logic       prog_fail,
  input logic       erase_fail
);
  p_quiet_when_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> arr_op == 3'd0);
  p_one_suspend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_susp, erase_susp}));
  p_susp_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_susp |-> ready);
  p_pfail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fail && !clr_err) |=> prog_fail);
  p_efail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_fail && !clr_err) |=> erase_fail);
  p_vpp_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready && !prog_susp && !erase_susp && !vpp_ok) |=> vpp_err);
  p_vpp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !vpp_ok && !resume_req) |=> ready);
  p_hold_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_susp && !resume_req) |=> prog_susp);
  p_nest_erase_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_susp && start && !op_erase && vpp_ok) |=> !prog_susp);
endmodule

bind flash_seq flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .vpp_ok(vpp_ok),
  .clr_err(clr_err), .resume_req(resume_req), .arr_op(arr_op), .ready(ready),
  .prog_susp(prog_susp), .erase_susp(erase_susp), .vpp_err(vpp_err),
  .prog_fail(prog_fail), .erase_fail(erase_fail)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int AW = 21, DW = 16, BLK_W = 15;
  localparam int PGM_CYC = 8, ZERO_CYC = 12, ERS_CYC = 20;

  logic clk = 0, rst_n = 0;
  logic start = 0, op_erase = 0, suspend_req = 0, resume_req = 0;
  logic vpp_ok = 1, lock_err = 0, clr_err = 0, verify_ok;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [2:0] arr_op;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic ready, prog_susp, erase_susp, vpp_err, lock_fail, prog_fail, erase_fail;
  logic ok_w = 1, ok_z = 1, ok_e = 1;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;
  assign verify_ok = (arr_op == 3'd2) ? ok_w : (arr_op == 3'd4) ? ok_z : ok_e;

  flash_seq uut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  localparam logic [47:0] VEC [0:5] = '{
    {4'd0, 24'h012345, 16'hBEEF, 4'h7},
    {4'd0, 24'h1FFFFF, 16'h0000, 4'h6},
    {4'd1, 24'h0ABCDE, 16'h0000, 4'h7},
    {4'd1, 24'h1FFFFF, 16'h0000, 4'h3},
    {4'd1, 24'h007FFF, 16'h0000, 4'h5},
    {4'd0, 24'h000000, 16'hFFFF, 4'h7}
  };

  int hist [0:7];
  logic [AW-1:0] seen_w, seen_b;
  logic [DW-1:0] seen_d;

  task automatic run_op(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    for (int i = 0; i < 8; i++) hist[i] = 0;
    @(negedge clk); start = 1; op_erase = op; addr = a; wdata = d;
    @(negedge clk); start = 0;
    for (int g = 0; g < 1000 && !ready; g++) begin
      hist[arr_op]++;
      if (arr_op == 3'd1) begin seen_w = arr_addr; seen_d = arr_data; end
      if (arr_op == 3'd3 || arr_op == 3'd5) seen_b = arr_addr;
      @(negedge clk);
      if (poke && g == 1) begin start = 1; op_erase = ~op; addr = '1; end
      else start = 0;
    end
    start = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;
  endtask

  initial begin
    int n, k, m;
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "ready", ready, 1);
    check("R1", "arr_op", arr_op, 0);
    check("R1", "flags", {prog_susp, erase_susp, vpp_err, lock_fail, prog_fail, erase_fail}, 0);

    for (int v = 0; v < 6; v++) begin
      logic op; logic [3:0] ok;
      op = VEC[v][44]; a = VEC[v][40:20]; ok = VEC[v][3:0];
      ok_w = ok[0]; ok_z = ok[1]; ok_e = ok[2];
      run_op(op, a, VEC[v][19:4], 0);
      if (!op) begin
        check("R2", "program cycles", hist[1], PGM_CYC);
        check("R2", "verify cycles", hist[2], 1);
        check("R2", "word addr", seen_w, a);
        check("R2", "word data", seen_d, VEC[v][19:4]);
        check("R4", "prog_fail", prog_fail, !ok[0]);
      end else begin
        check("R3", "zero cycles", hist[3], ZERO_CYC);
        check("R3", "zero verify", hist[4], 1);
        check("R4", "erase cycles", hist[5], ok[1] ? ERS_CYC : 0);
        check("R3", "ones verify", hist[6], ok[1] ? 1 : 0);
        check("R3", "block base", seen_b, a & ~((AW'(1) << BLK_W) - 1));
        check("R4", "erase_fail", erase_fail, !(ok[1] && ok[2]));
      end
      check("R2", "ready after", ready, 1);
      repeat (3) @(negedge clk);
      check("R5", "fail sticky", {prog_fail, erase_fail}, op ? {1'b0, !(ok[1] && ok[2])} : {!ok[0], 1'b0});
      pulse_clr();
      check("R5", "fail cleared", {prog_fail, erase_fail}, 0);
    end
    ok_w = 1; ok_z = 1; ok_e = 1;

    // R6 supply error
    @(negedge clk); vpp_ok = 0; start = 1; op_erase = 0;
    @(negedge clk); start = 0;
    check("R6", "vpp_err", vpp_err, 1);
    check("R6", "ready", ready, 1);
    repeat (2) @(negedge clk);
    check("R6", "no step", arr_op, 0);
    vpp_ok = 1; pulse_clr();
    check("R5", "vpp cleared", vpp_err, 0);

    // R7 lock error
    @(negedge clk); lock_err = 1; start = 1; op_erase = 1;
    @(negedge clk); start = 0; lock_err = 0;
    check("R7", "lock_fail", lock_fail, 1);
    check("R7", "no step", {ready, arr_op}, 4'b1000);
    pulse_clr();

    // R12 start while busy, resume while idle
    run_op(0, 21'h000123, 16'h1234, 1);
    check("R12", "busy start ignored prog", hist[1], PGM_CYC);
    check("R12", "busy start no erase", hist[3] + hist[5], 0);
    @(negedge clk); resume_req = 1;
    @(negedge clk); resume_req = 0;
    check("R12", "resume idle", {ready, arr_op}, 4'b1000);

    // R8/R9/R10 program suspend
    @(negedge clk); start = 1; op_erase = 0; addr = 21'h000777; wdata = 16'hA5A5;
    @(negedge clk); start = 0;
    @(negedge clk);
    @(negedge clk); suspend_req = 1;
    check("R10", "pre-suspend op", arr_op, 1);
    @(negedge clk); suspend_req = 1; start = 1;
    check("R8", "prog_susp", {prog_susp, erase_susp, ready}, 3'b101);
    check("R8", "arr idle", arr_op, 0);
    @(negedge clk); suspend_req = 0; start = 0;
    check("R9", "still suspended", prog_susp, 1);
    repeat (3) @(negedge clk);
    check("R9", "quiet", arr_op, 0);
    resume_req = 1;
    @(negedge clk); resume_req = 0;
    n = 0;
    for (int g = 0; g < 100 && arr_op == 3'd1; g++) begin n++; @(negedge clk); end
    check("R10", "remaining program", n, PGM_CYC + 1 - 3);
    check("R10", "verify after resume", arr_op, 2);
    @(negedge clk);
    check("R10", "done", {ready, prog_susp}, 2'b10);

    // R11 nested program in erase suspend
    @(negedge clk); start = 1; op_erase = 1; addr = 21'h154321;
    @(negedge clk); start = 0;
    for (int g = 0; g < 100 && arr_op != 3'd5; g++) @(negedge clk);
    k = 0;
    repeat (3) begin k++; @(negedge clk); end
    suspend_req = 1; k++;
    @(negedge clk); suspend_req = 0;
    check("R8", "erase_susp", {prog_susp, erase_susp, ready}, 3'b011);
    start = 1; op_erase = 0; addr = 21'h000010; wdata = 16'h5A5A;
    @(negedge clk); start = 0; suspend_req = 1;
    check("R11", "nested running", {ready, erase_susp}, 2'b01);
    check("R11", "nested addr", arr_addr, 21'h000010);
    n = 0;
    for (int g = 0; g < 100 && arr_op == 3'd1; g++) begin n++; @(negedge clk); suspend_req = 0; end
    check("R11", "nested program", n, PGM_CYC);
    @(negedge clk);
    check("R11", "back to erase suspend", {ready, prog_susp, erase_susp, arr_op}, 6'b101000);
    resume_req = 1;
    @(negedge clk); resume_req = 0;
    m = 0;
    check("R11", "erase block addr", arr_addr, 21'h150000);
    for (int g = 0; g < 100 && arr_op == 3'd5; g++) begin m++; @(negedge clk); end
    check("R10", "erase total", k + m, ERS_CYC + 1);
    check("R11", "ones verify", arr_op, 6);
    @(negedge clk);
    check("R11", "erase done", {ready, erase_susp, erase_fail}, 3'b100);

    // R13 reset aborts
    @(negedge clk); start = 1; op_erase = 1; addr = 21'h0;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    rst_n = 0; #1;
    check("R13", "abort op", arr_op, 0);
    check("R13", "abort ready", ready, 1);
    @(negedge clk); rst_n = 1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule